// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of sixteen general-purpose pins behind a word-addressed register port. Software writes the output data and turns drivers on per pin; the block drives the pad output and pad enable vectors from that state. It brings the pad input levels through a synchroniser, so software can read them. It also watches every pin for an interrupt condition.

Each pin has its own trigger. A type bit and a polarity bit together pick one of four modes: low level, high level, falling edge or rising edge. A pin that meets its condition sets a sticky status bit, and software clears that bit by writing a one to it. The block raises one interrupt line whenever a status bit is set on a pin whose interrupt is enabled. Software changes output enable, interrupt enable, type and polarity only through paired set and clear registers. A one in the written word sets or clears that bit and a zero leaves it alone, so read-modify-write is never needed.

The address is a word index: the byte offset divided by four.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the pad output and pad enable vectors are zero, the interrupt line is low, and the output data, output enable, interrupt enable, type and polarity registers all read as zero.
- R2: A write to word 1 (byte offset 0x04) or to word 0 (0x00) loads the output data register. From the next cycle padOut shows the written value, and word 1 reads it back.
- R3: Word 0 reads the pad levels after a two-flop synchroniser. A pad change made just after a clock edge is first returned by the read that is captured at the third following edge.
- R4: Each control field has two words: output enable at words 4/5, interrupt enable at 8/9, type at 10/11, polarity at 12/13. The even word is the set word and the odd word is the clear word. A one bit sets or clears the matching control bit, and a zero bit leaves it unchanged. Both words read back the current value. The output enable value drives padOe directly.
- R5: The trigger mode is chosen by type bit T and polarity bit P. T=0,P=0 is low level. T=0,P=1 is high level. T=1,P=0 is falling edge. T=1,P=1 is rising edge. Edges are found by comparing the synchronised level with its value one cycle earlier. A met condition sets bit i of the status word (word 14, offset 0x38) at the third edge after the pad change.
- R6: If a level-triggered status bit is cleared while its level still holds, it reads as set again.
- R7: If an edge event and a clear write to the same status bit land on the same clock edge, the bit ends up set.
- R8: Writing word 14 clears only the status bits written as one. Bits written as zero keep their value.
- R9: irq is high exactly when some pin has both its status bit and its interrupt enable bit set. Status detection runs whether or not the pin is enabled.
- R10: Bits 31:16 of every read are zero. Reads of unmapped words return zero, and writes to unmapped words change no state.
- R11: rdData is registered. It takes the addressed value on the edge where rdEn is high and holds its value while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, captures rdData at the edge |
| addr | input | 6 | Word index of the register |
| wrData | input | 16 | Write data, one bit per pin |
| rdData | output | 32 | Registered read data |
| padIn | input | 16 | Pad input levels, asynchronous |
| padOut | output | 16 | Pad output levels |
| padOe | output | 16 | Pad output enables, active high |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets these corner cases:

- **Synchroniser latency.** It reads the input word on three back-to-back cycles after a pad change. A synchroniser stage too few or too many moves the first read that shows the new value.
- **Sticky and level behaviour.** It clears a high-level pin while the pad stays high and expects the bit to come back. It also clears one status bit next to other sticky bits. A design that takes level status as sticky, or clears the whole word, fails here.
- **Clear versus edge.** It lines a clear write up with the edge on which a rising edge arrives. Letting the clear win loses the bit.
- **Control pairs and enables.** It writes zero bits to the set and clear words and checks that nothing else moves. It then checks that irq follows only enabled pins, and that detection still runs while a pin is masked. This catches pairs that overwrite instead of merging, and enables applied at the detector.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word indexes of the register map (byte offset divided by four)
  localparam int unsigned WordPinIn   = 0;
  localparam int unsigned WordDataOut = 1;
  localparam int unsigned WordOeSet   = 4;
  localparam int unsigned WordOeClr   = 5;
  localparam int unsigned WordIeSet   = 8;
  localparam int unsigned WordIeClr   = 9;
  localparam int unsigned WordTypSet  = 10;
  localparam int unsigned WordTypClr  = 11;
  localparam int unsigned WordPolSet  = 12;
  localparam int unsigned WordPolClr  = 13;
  localparam int unsigned WordStat    = 14;

  // Index of each set/clear control field
  localparam int unsigned CtlOe    = 0;
  localparam int unsigned CtlIe    = 1;
  localparam int unsigned CtlTyp   = 2;
  localparam int unsigned CtlPol   = 3;
  localparam int unsigned NumCtl   = 4;

  // Write strobes from control to datapath
  typedef struct packed {
    logic dataWr;
    logic [NumCtl-1:0] ctlSet;
    logic [NumCtl-1:0] ctlClr;
    logic statClr;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned Width  = 16,
  parameter int unsigned Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] d,
  output logic [Width-1:0] q
);

  logic [Width-1:0] stage [Stages];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < Stages; k++) stage[k] <= '0;
    end else begin
      stage[0] <= d;
      for (int k = 1; k < Stages; k++) stage[k] <= stage[k-1];
    end
  end

  assign q = stage[Stages-1];

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned Width = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setEn,
  input  logic             clrEn,
  input  logic [Width-1:0] mask,
  output logic [Width-1:0] q
);

  logic [Width-1:0] setBits;
  logic [Width-1:0] clrBits;

  always_comb begin
    setBits = setEn ? mask : '0;
    clrBits = clrEn ? mask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= (q | setBits) & ~clrBits;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned AddrW   = 6,
  parameter int unsigned NumPins = 16,
  parameter int unsigned RegW    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [AddrW-1:0]   addr,
  output wrStrobe_t          wrStb,
  input  logic [NumPins-1:0] pinLvl,
  input  logic [NumPins-1:0] dataOut,
  input  logic [NumPins-1:0] ctlVal [NumCtl],
  input  logic [NumPins-1:0] stat,
  output logic [RegW-1:0]    rdData
);

  logic [NumPins-1:0] rdNext;

  // Write decode
  always_comb begin
    wrStb = '0;
    if (wrEn) begin
      case (addr)
        AddrW'(WordPinIn),
        AddrW'(WordDataOut): wrStb.dataWr         = 1'b1;
        AddrW'(WordOeSet):   wrStb.ctlSet[CtlOe]  = 1'b1;
        AddrW'(WordOeClr):   wrStb.ctlClr[CtlOe]  = 1'b1;
        AddrW'(WordIeSet):   wrStb.ctlSet[CtlIe]  = 1'b1;
        AddrW'(WordIeClr):   wrStb.ctlClr[CtlIe]  = 1'b1;
        AddrW'(WordTypSet):  wrStb.ctlSet[CtlTyp] = 1'b1;
        AddrW'(WordTypClr):  wrStb.ctlClr[CtlTyp] = 1'b1;
        AddrW'(WordPolSet):  wrStb.ctlSet[CtlPol] = 1'b1;
        AddrW'(WordPolClr):  wrStb.ctlClr[CtlPol] = 1'b1;
        AddrW'(WordStat):    wrStb.statClr        = 1'b1;
        default:             wrStb                = '0;
      endcase
    end
  end

  // Read mux
  always_comb begin
    case (addr)
      AddrW'(WordPinIn):                 rdNext = pinLvl;
      AddrW'(WordDataOut):               rdNext = dataOut;
      AddrW'(WordOeSet),  AddrW'(WordOeClr):  rdNext = ctlVal[CtlOe];
      AddrW'(WordIeSet),  AddrW'(WordIeClr):  rdNext = ctlVal[CtlIe];
      AddrW'(WordTypSet), AddrW'(WordTypClr): rdNext = ctlVal[CtlTyp];
      AddrW'(WordPolSet), AddrW'(WordPolClr): rdNext = ctlVal[CtlPol];
      AddrW'(WordStat):                  rdNext = stat;
      default:                           rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= RegW'(rdNext);
  end

  // R11: read data only moves on a read strobe
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R10: reserved upper bits never carry data
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[RegW-1:NumPins] == '0);

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NumPins    = 16,
  parameter int unsigned SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          wrStb,
  input  logic [NumPins-1:0] wrMask,
  input  logic [NumPins-1:0] padIn,
  output logic [NumPins-1:0] padOut,
  output logic [NumPins-1:0] padOe,
  output logic               irq,
  output logic [NumPins-1:0] pinLvl,
  output logic [NumPins-1:0] dataOut,
  output logic [NumPins-1:0] ctlVal [NumCtl],
  output logic [NumPins-1:0] stat
);

  logic [NumPins-1:0] prevLvl;
  logic [NumPins-1:0] hit;
  logic [NumPins-1:0] clrMask;
  logic [NumPins-1:0] typ;
  logic [NumPins-1:0] pol;
  logic [NumPins-1:0] ie;

  // Output data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= '0;
    else if (wrStb.dataWr) dataOut <= wrMask;
  end

  // Set/clear control fields
  for (genvar c = 0; c < NumCtl; c++) begin : g_ctl
    gpio_setclr_reg #(.Width(NumPins)) u_reg (
      .clk   (clk),
      .rstN  (rstN),
      .setEn (wrStb.ctlSet[c]),
      .clrEn (wrStb.ctlClr[c]),
      .mask  (wrMask),
      .q     (ctlVal[c])
    );
  end

  assign typ    = ctlVal[CtlTyp];
  assign pol    = ctlVal[CtlPol];
  assign ie     = ctlVal[CtlIe];
  assign padOe  = ctlVal[CtlOe];
  assign padOut = dataOut;

  // Input synchroniser and previous sample
  gpio_sync #(.Width(NumPins), .Stages(SyncStages)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (padIn),
    .q    (pinLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= pinLvl;
  end

  // Per-pin trigger detection
  for (genvar p = 0; p < NumPins; p++) begin : g_det
    always_comb begin
      unique case ({typ[p], pol[p]})
        2'b00:   hit[p] = ~pinLvl[p];
        2'b01:   hit[p] =  pinLvl[p];
        2'b10:   hit[p] = ~pinLvl[p] &  prevLvl[p];
        default: hit[p] =  pinLvl[p] & ~prevLvl[p];
      endcase
    end
  end

  // Sticky status: event beats a same-cycle clear
  assign clrMask = wrStb.statClr ? wrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= (stat & ~clrMask) | hit;
  end

  assign irq = |(stat & ie);

  // R2: pad output follows a data write on the next cycle
  a_r2_pad_out: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.dataWr |=> (padOut == $past(wrMask)));

  // R4: set word raises exactly the written ones
  a_r4_oe_set: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.ctlSet[CtlOe] |=> ((padOe & $past(wrMask)) == $past(wrMask)));

  // R4: clear word drops exactly the written ones
  a_r4_oe_clr: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.ctlClr[CtlOe] |=> ((padOe & $past(wrMask)) == '0));

  // R4: enables stay put without a pair write
  a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb.ctlSet[CtlOe] || wrStb.ctlClr[CtlOe]) |=> $stable(padOe));

  // R6: a held high level is in status on the next cycle
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (|(~typ & pol & pinLvl)) |=>
      ((stat & $past(~typ & pol & pinLvl)) == $past(~typ & pol & pinLvl)));

  // R7: a rising edge lands in status even against a clear
  a_r7_rise_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|(typ & pol & pinLvl & ~prevLvl)) |=>
      ((stat & $past(typ & pol & pinLvl & ~prevLvl)) ==
        $past(typ & pol & pinLvl & ~prevLvl)));

  // R8: bits written as zero keep their status
  a_r8_keep_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.statClr |=> ((stat & $past(stat & ~wrMask)) == $past(stat & ~wrMask)));

  // R9: a fully masked bank never interrupts
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ie == '0) |-> !irq);

  // R9: an interrupt always has a pending status behind it
  a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stat != '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NumPins    = 16,
  parameter int unsigned AddrW      = 6,
  parameter int unsigned RegW       = 32,
  parameter int unsigned SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [AddrW-1:0]   addr,
  input  logic [NumPins-1:0] wrData,
  output logic [RegW-1:0]    rdData,
  input  logic [NumPins-1:0] padIn,
  output logic [NumPins-1:0] padOut,
  output logic [NumPins-1:0] padOe,
  output logic               irq
);

  wrStrobe_t          wrStb;
  logic [NumPins-1:0] pinLvl;
  logic [NumPins-1:0] dataOut;
  logic [NumPins-1:0] ctlVal [NumCtl];
  logic [NumPins-1:0] stat;

  gpio_irq_ctrl #(
    .AddrW   (AddrW),
    .NumPins (NumPins),
    .RegW    (RegW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrStb   (wrStb),
    .pinLvl  (pinLvl),
    .dataOut (dataOut),
    .ctlVal  (ctlVal),
    .stat    (stat),
    .rdData  (rdData)
  );

  gpio_irq_datapath #(
    .NumPins    (NumPins),
    .SyncStages (SyncStages)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .wrMask  (wrData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .irq     (irq),
    .pinLvl  (pinLvl),
    .dataOut (dataOut),
    .ctlVal  (ctlVal),
    .stat    (stat)
  );

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [31:0] rdData;
  logic [15:0] padIn = '0;
  logic [15:0] padOut;
  logic [15:0] padOe;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .irq    (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Each access takes one clock edge; called just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 padOut", 32'(padOut), 32'h0);
    check("R1 padOe", 32'(padOe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rdData", rdData, 32'h0);
    rd(6'd1, v);  check("R1 data out", v, 32'h0);
    rd(6'd4, v);  check("R1 out enable", v, 32'h0);
    rd(6'd9, v);  check("R1 int enable", v, 32'h0);
    rd(6'd10, v); check("R1 type", v, 32'h0);
    rd(6'd13, v); check("R1 polarity", v, 32'h0);
  endtask

  task automatic testDataOut();
    logic [31:0] v;
    wr(6'd1, 16'hA5C3);
    check("R2 padOut word1", 32'(padOut), 32'h0000A5C3);
    rd(6'd1, v); check("R2 readback", v, 32'h0000A5C3);
    wr(6'd0, 16'h1234);
    check("R2 padOut word0", 32'(padOut), 32'h00001234);
    rd(6'd1, v); check("R2 readback word0", v, 32'h00001234);
  endtask

  task automatic testSetClr();
    logic [31:0] v;
    wr(6'd4, 16'h00F0);
    check("R4 oe set", 32'(padOe), 32'h00F0);
    wr(6'd4, 16'h0F00);
    check("R4 oe set keeps zeros", 32'(padOe), 32'h0FF0);
    wr(6'd5, 16'h0030);
    check("R4 oe clear", 32'(padOe), 32'h0FC0);
    rd(6'd4, v); check("R4 oe read set word", v, 32'h0FC0);
    rd(6'd5, v); check("R4 oe read clear word", v, 32'h0FC0);
    wr(6'd8, 16'h8001);
    wr(6'd9, 16'h8000);
    rd(6'd8, v); check("R4 ie pair", v, 32'h0001);
    wr(6'd9, 16'h0001);
    rd(6'd9, v); check("R4 ie cleared", v, 32'h0000);
  endtask

  task automatic testSyncLatency();
    logic [31:0] v;
    padIn = 16'hFFF1;
    rd(6'd0, v); check("R3 first edge old", v, 32'h0);
    rd(6'd0, v); check("R3 second edge old", v, 32'h0);
    rd(6'd0, v); check("R3 third edge new", v, 32'h0000FFF1);
  endtask

  task automatic testModes();
    logic [31:0] v;
    // pin0 low level, pin1 high level, pin2 falling, pin3 rising (R5)
    wr(6'd10, 16'h000C);
    wr(6'd12, 16'h000A);
    wr(6'd14, 16'hFFFF);
    waitCycles(3);
    rd(6'd14, v); check("R5 quiet status", v, 32'h0);
    padIn = 16'hFFFF;
    waitCycles(3);
    rd(6'd14, v); check("R5 high level and rising", v, 32'h000A);
    check("R9 masked detection irq low", 32'(irq), 32'h0);
    wr(6'd14, 16'h000F);
    rd(6'd14, v); check("R6 level comes back", v, 32'h0002);
    padIn = 16'hFFF0;
    waitCycles(3);
    rd(6'd14, v); check("R5 low level and falling", v, 32'h0007);
  endtask

  task automatic testW1c();
    logic [31:0] v;
    wr(6'd14, 16'h0002);
    rd(6'd14, v); check("R8 single bit clear", v, 32'h0005);
    wr(6'd14, 16'h0004);
    rd(6'd14, v); check("R8 sticky edge cleared", v, 32'h0001);
  endtask

  task automatic testEdgeVsClear();
    logic [31:0] v;
    padIn = 16'hFFF8;
    waitCycles(2);
    wr(6'd14, 16'h0008);   // lands on the edge that records the rise
    rd(6'd14, v); check("R7 edge beats clear", v, 32'h0009);
    wr(6'd14, 16'h0008);
    rd(6'd14, v); check("R7 later clear works", v, 32'h0001);
  endtask

  task automatic testIrq();
    check("R9 irq masked", 32'(irq), 32'h0);
    wr(6'd8, 16'h0008);
    check("R9 enabled pin idle", 32'(irq), 32'h0);
    wr(6'd8, 16'h0001);
    check("R9 irq raised", 32'(irq), 32'h1);
    wr(6'd9, 16'h0001);
    check("R9 irq dropped", 32'(irq), 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    wr(6'd2, 16'hFFFF);
    wr(6'd15, 16'hFFFF);
    rd(6'd2, v);  check("R10 unmapped read", v, 32'h0);
    rd(6'd4, v);  check("R10 oe untouched", v, 32'h0FC0);
    rd(6'd1, v);  check("R10 data untouched", v, 32'h1234);
    rd(6'd14, v); check("R10 status untouched", v, 32'h0001);
    rd(6'd0, v);  check("R10 upper bits zero", v, 32'h0000FFF8);
  endtask

  task automatic testReadHold();
    logic [31:0] v;
    rd(6'd1, v);
    wr(6'd1, 16'h5555);
    check("R11 hold after write", rdData, 32'h1234);
    addr = 6'd4;
    waitCycles(2);
    check("R11 hold idle", rdData, 32'h1234);
    rd(6'd1, v); check("R11 new read", v, 32'h5555);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataOut();
    testSetClr();
    testSyncLatency();
    testModes();
    testW1c();
    testEdgeVsClear();
    testIrq();
    testUnmapped();
    testReadHold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule